// File: doc/BRIEF.md
# SPI Flash Erase/Program Sequencer

This block drives an external serial NOR flash from the host side to carry out one write-type operation per request. The operation is either a 4 KB sector erase or a page program. A request gives the operation, a 24-bit flash address and, for a program, a byte count. The program payload then arrives over a valid/ready stream. The sequencer opens a chip-select frame for each step. It sets the write latch, reads status back to confirm that the latch took, and sends the erase or program command with its address, most significant byte first. It then reads status repeatedly until the flash reports that it is idle.

Each step is its own frame. Chip-select is released one system clock after the serial clock falls from the last bit of the last byte, so no stray edge reaches the flash. Between frames chip-select stays high for a programmable minimum number of clocks. The serial clock runs in mode 0 and is derived from the system clock by an even divider. The operation ends with a one-cycle completion pulse and a result code: success, latch not set, operation rejected by the flash, or poll limit reached.

Top module: `spi_flash_wrseq`

## Requirements
- R1: While reset is held and right after it, spi_cs_n is 1, spi_sck is 0, req_ready is 1 and done is 0.
- R2: Every accepted request begins with a one-byte frame carrying 06h.
- R3: The next frame is two bytes: 05h, then a dummy 00h. Its second received byte is status. If bit 1 (latch) is 0, the operation ends with result code 1 and no further frame is sent.
- R4: For an erase (req_op = 0), the command frame is exactly four bytes: 20h, A[23:16], A[15:8], A[7:0].
- R5: For a program (req_op = 1), the command frame is 02h, the three address bytes, and then req_len+1 payload bytes in stream order. A payload byte is taken on a cycle with wr_valid and wr_ready both high. wr_ready is only high while spi_cs_n is 0.
- R6: Each frame contains exactly eight rising spi_sck edges per byte. spi_cs_n rises only after spi_sck has been low for at least one clock.
- R7: Between two frames, spi_cs_n stays high for at least CS_GAP system clocks.
- R8: In mode 0, spi_sck is low while spi_cs_n is high and only changes while spi_cs_n is low. spi_mosi holds steady while spi_sck is high.
- R9: Every high phase of spi_sck lasts CLK_DIV/2 system clocks.
- R10: After the command frame, two-byte status frames (05h, 00h) repeat while status bit 0 (busy) reads 1. When busy reads 0 and the latch bit reads 0, the result is code 0.
- R11: When busy reads 0 but the latch bit still reads 1, the result is code 2 (rejected).
- R12: If POLL_MAX status frames in a row all read busy = 1, the result is code 3 and no further frame is sent.
- R13: req_ready is low from the cycle after a request is accepted until completion. done is a single-cycle pulse that falls in a cycle where req_ready is 1, and err_code holds the result from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_op | input | 1 | 0 = sector erase, 1 = page program |
| req_addr | input | 24 | Flash byte address |
| req_len | input | $clog2(MAX_BYTES) | Program payload length minus one |
| wr_data | input | 8 | Program payload byte |
| wr_valid | input | 1 | Payload byte present |
| wr_ready | output | 1 | Payload byte consumed this cycle |
| done | output | 1 | Operation finished (one cycle) |
| err_code | output | 2 | Result: 0 ok, 1 latch not set, 2 rejected, 3 timeout |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two things can happen in the same system clock: the serial clock falls on the eighth bit of a payload byte, and the sequencer chooses the next byte of the frame and fetches it from the stream. In the 256-byte program the stream is never stalled, so each payload byte is already valid when the previous byte ends. In the short program, valid is dropped before some bytes, so the frame waits with chip-select low. In both cases the checks are the same: the flash model's record of the payload order, the edge count per byte, and the measured width of each high phase. A slip in that shared cycle would show up as a lost, repeated or shortened bit.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   localparam int unsigned ADDR_W = 24;

   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_RDST  = 8'h05;
   localparam logic [7:0] OPC_ERASE = 8'h20;
   localparam logic [7:0] OPC_PROG  = 8'h02;

   localparam int unsigned ST_BUSY_BIT  = 0;
   localparam int unsigned ST_LATCH_BIT = 1;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_NOLATCH = 2'd1,
      RES_REJECT  = 2'd2,
      RES_TIMEOUT = 2'd3
   } fseq_res_e;

   typedef enum logic [1:0] {
      FR_LATCH = 2'd0,
      FR_CHECK = 2'd1,
      FR_CMD   = 2'd2,
      FR_POLL  = 2'd3
   } fseq_frame_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_GAP   = 2'd1,
      SQ_LOAD  = 2'd2,
      SQ_SHIFT = 2'd3
   } fseq_state_e;

endpackage

// File: rtl/fseq_shift.sv
module fseq_shift #(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   output logic [7:0] rx,
   output logic       done,
   output logic       sck,
   output logic       mosi,
   input  logic       miso
);
   localparam int unsigned HALF = CLK_DIV / 2;

   logic       busy;
   logic       tick;
   logic [7:0] osr;
   logic [7:0] isr;
   logic [2:0] nbit;

   generate
      if (HALF == 1) begin : g_nodiv
         assign tick = busy;
      end else begin : g_div
         localparam int unsigned CW = $clog2(HALF);
         logic [CW-1:0] hcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hcnt <= '0;
            end else if (!busy) begin
               hcnt <= '0;
            end else if (hcnt == CW'(HALF - 1)) begin
               hcnt <= '0;
            end else begin
               hcnt <= hcnt + 1'b1;
            end
         end
         assign tick = busy && (hcnt == CW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sck  <= 1'b0;
         osr  <= '0;
         isr  <= '0;
         nbit <= '0;
         done <= 1'b0;
         rx   <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy <= 1'b1;
            osr  <= tx;
            nbit <= '0;
            sck  <= 1'b0;
         end else if (tick) begin
            if (!sck) begin
               sck <= 1'b1;
               isr <= {isr[6:0], miso};
            end else begin
               sck <= 1'b0;
               if (nbit == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  rx   <= isr;
               end else begin
                  nbit <= nbit + 1'b1;
                  osr  <= {osr[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign mosi = osr[7];

endmodule

// File: rtl/fseq_frame_src.sv
module fseq_frame_src
   import fseq_pkg::*;
#(
   parameter int unsigned IW = 9,
   parameter int unsigned LW = 8
) (
   input  fseq_frame_e        frame,
   input  logic [IW-1:0]      idx,
   input  logic               op_prog,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [LW-1:0]      len_m1,
   input  logic [7:0]         wr_data,
   output logic [7:0]         tx_byte,
   output logic               is_data,
   output logic               is_last
);
   logic [IW-1:0] flen;

   always_comb begin
      tx_byte = 8'h00;
      is_data = 1'b0;
      flen    = IW'(1);
      unique case (frame)
         FR_LATCH: begin
            tx_byte = OPC_WREN;
         end
         FR_CHECK, FR_POLL: begin
            flen    = IW'(2);
            tx_byte = (idx == '0) ? OPC_RDST : 8'h00;
         end
         default: begin
            flen = op_prog ? (IW'(5) + IW'(len_m1)) : IW'(4);
            if (idx == IW'(0)) begin
               tx_byte = op_prog ? OPC_PROG : OPC_ERASE;
            end else if (idx == IW'(1)) begin
               tx_byte = addr[23:16];
            end else if (idx == IW'(2)) begin
               tx_byte = addr[15:8];
            end else if (idx == IW'(3)) begin
               tx_byte = addr[7:0];
            end else begin
               tx_byte = wr_data;
               is_data = 1'b1;
            end
         end
      endcase
   end

   assign is_last = (idx == flen - IW'(1));

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
   import fseq_pkg::*;
#(
   parameter int unsigned CS_GAP   = 4,
   parameter int unsigned POLL_MAX = 1000,
   parameter int unsigned IW       = 9,
   parameter int unsigned LW       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LW-1:0]     req_len,
   output logic              req_ready,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic              src_is_data,
   input  logic              src_is_last,
   input  logic              sh_done,
   input  logic [7:0]        sh_rx,
   output logic              sh_start,
   output fseq_frame_e       frame,
   output logic [IW-1:0]     idx,
   output logic              op_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LW-1:0]     len_q,
   output logic              cs_n,
   output logic              done,
   output logic [1:0]        err_code
);
   localparam int unsigned GW = $clog2(CS_GAP + 1);
   localparam int unsigned PW = $clog2(POLL_MAX + 1);

   fseq_state_e   state;
   logic [GW-1:0] gcnt;
   logic [PW-1:0] pcnt;

   assign req_ready = (state == SQ_IDLE);
   assign wr_ready  = (state == SQ_LOAD) && src_is_data;
   assign sh_start  = (state == SQ_LOAD) && (!src_is_data || wr_valid);
   assign cs_n      = !((state == SQ_LOAD) || (state == SQ_SHIFT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         frame    <= FR_LATCH;
         idx      <= '0;
         gcnt     <= '0;
         pcnt     <= '0;
         op_q     <= 1'b0;
         addr_q   <= '0;
         len_q    <= '0;
         done     <= 1'b0;
         err_code <= RES_OK;
      end else begin
         done <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (req_valid) begin
                  op_q   <= req_op;
                  addr_q <= req_addr;
                  len_q  <= req_len;
                  frame  <= FR_LATCH;
                  pcnt   <= '0;
                  gcnt   <= '0;
                  state  <= SQ_GAP;
               end
            end
            SQ_GAP: begin
               if (gcnt == GW'(CS_GAP - 1)) begin
                  idx   <= '0;
                  state <= SQ_LOAD;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            SQ_LOAD: begin
               if (sh_start) begin
                  state <= SQ_SHIFT;
               end
            end
            default: begin
               if (sh_done) begin
                  gcnt <= '0;
                  if (!src_is_last) begin
                     idx   <= idx + 1'b1;
                     state <= SQ_LOAD;
                  end else begin
                     state <= SQ_GAP;
                     unique case (frame)
                        FR_LATCH: frame <= FR_CHECK;
                        FR_CHECK: begin
                           if (sh_rx[ST_LATCH_BIT]) begin
                              frame <= FR_CMD;
                           end else begin
                              state    <= SQ_IDLE;
                              done     <= 1'b1;
                              err_code <= RES_NOLATCH;
                           end
                        end
                        FR_CMD: begin
                           frame <= FR_POLL;
                           pcnt  <= '0;
                        end
                        default: begin
                           if (!sh_rx[ST_BUSY_BIT]) begin
                              state    <= SQ_IDLE;
                              done     <= 1'b1;
                              err_code <= sh_rx[ST_LATCH_BIT] ? RES_REJECT : RES_OK;
                           end else if (pcnt == PW'(POLL_MAX - 1)) begin
                              state    <= SQ_IDLE;
                              done     <= 1'b1;
                              err_code <= RES_TIMEOUT;
                           end else begin
                              pcnt <= pcnt + 1'b1;
                           end
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/spi_flash_wrseq.sv
module spi_flash_wrseq
   import fseq_pkg::*;
#(
   parameter int unsigned CLK_DIV   = 4,
   parameter int unsigned CS_GAP    = 4,
   parameter int unsigned POLL_MAX  = 1000,
   parameter int unsigned MAX_BYTES = 256,
   localparam int unsigned LW       = $clog2(MAX_BYTES),
   localparam int unsigned IW       = $clog2(MAX_BYTES + 5)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_op,
   input  logic [23:0]       req_addr,
   input  logic [LW-1:0]     req_len,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic              done,
   output logic [1:0]        err_code,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   generate
      if ((CLK_DIV < 2) || ((CLK_DIV % 2) != 0)) begin : g_bad_div
         $error("CLK_DIV has to be even and no less than 2");
      end
      if (CS_GAP < 1) begin : g_bad_gap
         $error("CS_GAP has to be at least 1");
      end
      if (POLL_MAX < 1) begin : g_bad_poll
         $error("POLL_MAX has to be at least 1");
      end
      if ((MAX_BYTES < 2) || ((1 << LW) != MAX_BYTES)) begin : g_bad_len
         $error("MAX_BYTES has to be a power of two of at least 2");
      end
   endgenerate

   fseq_frame_e       frame;
   logic [IW-1:0]     idx;
   logic              op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LW-1:0]     len_q;
   logic [7:0]        tx_byte;
   logic              is_data;
   logic              is_last;
   logic              sh_start;
   logic              sh_done;
   logic [7:0]        sh_rx;

   fseq_frame_src #(.IW(IW), .LW(LW)) u_src (
      .frame   (frame),
      .idx     (idx),
      .op_prog (op_q),
      .addr    (addr_q),
      .len_m1  (len_q),
      .wr_data (wr_data),
      .tx_byte (tx_byte),
      .is_data (is_data),
      .is_last (is_last)
   );

   fseq_shift #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sh_start),
      .tx    (tx_byte),
      .rx    (sh_rx),
      .done  (sh_done),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .miso  (spi_miso)
   );

   fseq_ctrl #(
      .CS_GAP   (CS_GAP),
      .POLL_MAX (POLL_MAX),
      .IW       (IW),
      .LW       (LW)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_op      (req_op),
      .req_addr    (req_addr),
      .req_len     (req_len),
      .req_ready   (req_ready),
      .wr_valid    (wr_valid),
      .wr_ready    (wr_ready),
      .src_is_data (is_data),
      .src_is_last (is_last),
      .sh_done     (sh_done),
      .sh_rx       (sh_rx),
      .sh_start    (sh_start),
      .frame       (frame),
      .idx         (idx),
      .op_q        (op_q),
      .addr_q      (addr_q),
      .len_q       (len_q),
      .cs_n        (spi_cs_n),
      .done        (done),
      .err_code    (err_code)
   );

endmodule

// File: rtl/spi_flash_wrseq_chk.sv
module spi_flash_wrseq_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic done,
   input logic wr_ready,
   input logic spi_sck,
   input logic spi_cs_n,
   input logic spi_mosi
);

   assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   assert_sck_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spi_sck) |-> !spi_cs_n);

   assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

   assert_cs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> (!spi_sck && !$past(spi_sck)));

   assert_wr_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> !spi_cs_n);

   assert_accept_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_done_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind spi_flash_wrseq spi_flash_wrseq_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .wr_ready  (wr_ready),
   .spi_sck   (spi_sck),
   .spi_cs_n  (spi_cs_n),
   .spi_mosi  (spi_mosi)
);

// File: tb/test_spi_flash_wrseq.sv
`timescale 1ns/1ps
module test_spi_flash_wrseq;
   localparam int TCLK     = 10;
   localparam int CLK_DIV  = 4;
   localparam int HALF     = CLK_DIV / 2;
   localparam int CS_GAP   = 3;
   localparam int POLL_MAX = 6;
   localparam int MAXB     = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_op = 1'b0;
   logic [23:0] req_addr = '0;
   logic [7:0] req_len = '0;
   logic [7:0] wr_data = '0;
   logic       wr_valid = 1'b0;
   logic       wr_ready;
   logic       done;
   logic [1:0] err_code;
   logic       spi_sck;
   logic       spi_cs_n;
   logic       spi_mosi;
   logic       spi_miso = 1'b0;

   spi_flash_wrseq #(
      .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_MAX(POLL_MAX), .MAX_BYTES(MAXB)
   ) i_spi_flash_wrseq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .done(done), .err_code(err_code), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   always #(TCLK/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // flash model
   bit        m_latch, m_ignore, m_prot;
   int        m_busy, m_busyn;
   bit        in_frame = 0;
   int        bits = 0;
   logic [7:0] sh_in, osr;
   byte unsigned cur[$];
   byte unsigned got_b[$];
   int        got_l[$];
   longint    t_hi = -1, t_r = 0;
   longint    min_gap;
   int        bits_bad, half_bad;

   function automatic logic [7:0] status();
      return {6'b0, m_latch, (m_busy != 0)};
   endfunction

   always @(negedge spi_cs_n) begin
      in_frame = 1;
      bits = 0;
      cur.delete();
      if (t_hi >= 0 && ($time - t_hi) / TCLK < min_gap) min_gap = ($time - t_hi) / TCLK;
   end

   always @(posedge spi_sck) if (!spi_cs_n) begin
      t_r = $time;
      sh_in = {sh_in[6:0], spi_mosi};
      bits++;
      if (bits % 8 == 0) cur.push_back(sh_in);
   end

   always @(negedge spi_sck) if (!spi_cs_n) begin
      if ($time - t_r != HALF * TCLK) half_bad++;
      if (bits == 8 && cur.size() > 0 && cur[0] == 8'h05) osr = status();
      else osr = {osr[6:0], 1'b0};
      spi_miso = osr[7];
   end

   always @(posedge spi_cs_n) if (in_frame) begin
      in_frame = 0;
      t_hi = $time;
      if (bits % 8 != 0) bits_bad++;
      got_l.push_back(cur.size());
      foreach (cur[k]) got_b.push_back(cur[k]);
      if (cur.size() > 0) begin
         case (cur[0])
            8'h06: if (!m_ignore) m_latch = 1;
            8'h20, 8'h02: if (m_latch && !m_prot) begin
               if (m_busyn == 0) m_latch = 0; else m_busy = m_busyn;
            end
            8'h05: if (m_busy > 0) begin
               m_busy--;
               if (m_busy == 0) m_latch = 0;
            end
            default: ;
         endcase
      end
   end

   // per-clock monitor
   bit  active = 0;
   bit  got_done = 0;
   int  done_cnt = 0;
   logic [1:0] got_code;

   always @(negedge clk) if (rst_n && !finished) begin
      chk(!(spi_cs_n && spi_sck), "R8 sck high with cs released", spi_sck, 0);
      chk(req_ready == (!active || done), "R13 req_ready", req_ready, !active || done);
      if (done) begin
         done_cnt++;
         got_done = 1;
         got_code = err_code;
         active = 0;
      end else if (req_valid && req_ready) begin
         active = 1;
      end
   end

   function automatic byte unsigned pay(input int i);
      return byte'(i * 7 + 3) ^ 8'h5A;
   endfunction

   task automatic feed(input int n, input bit stall);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         if (stall && (i % 3 == 1)) begin
            wr_valid = 0;
            @(posedge clk); #1;
         end
         wr_valid = 1;
         wr_data = pay(i);
         do @(negedge clk); while (!wr_ready);
      end
      @(posedge clk); #1;
      wr_valid = 0;
   endtask

   task automatic run_op(input bit op, input logic [23:0] addr, input int lenm1,
                         input bit ign, input bit prot, input int busyn, input bit stall);
      byte unsigned eb[$];
      int el[$];
      int ecode, npoll;
      string otag;
      bit same;
      m_latch = 0; m_busy = 0; m_ignore = ign; m_prot = prot; m_busyn = busyn;
      got_b.delete(); got_l.delete();
      min_gap = 1000000; bits_bad = 0; half_bad = 0; done_cnt = 0;
      eb.push_back(8'h06); el.push_back(1);
      eb.push_back(8'h05); eb.push_back(8'h00); el.push_back(2);
      if (ign) ecode = 1;
      else begin
         eb.push_back(op ? 8'h02 : 8'h20);
         eb.push_back(addr[23:16]); eb.push_back(addr[15:8]); eb.push_back(addr[7:0]);
         if (op) for (int i = 0; i <= lenm1; i++) eb.push_back(pay(i));
         el.push_back(op ? 5 + lenm1 : 4);
         if (prot) begin npoll = 1; ecode = 2; end
         else if (busyn < POLL_MAX) begin npoll = busyn + 1; ecode = 0; end
         else begin npoll = POLL_MAX; ecode = 3; end
         for (int p = 0; p < npoll; p++) begin
            eb.push_back(8'h05); eb.push_back(8'h00); el.push_back(2);
         end
      end
      @(posedge clk); #1;
      req_valid = 1; req_op = op; req_addr = addr; req_len = 8'(lenm1);
      @(posedge clk); #1;
      req_valid = 0;
      if (op) fork feed(lenm1 + 1, stall); join_none
      while (!got_done) @(negedge clk);
      got_done = 0;
      repeat (3) @(negedge clk);
      case (ecode)
         0: otag = "R10 result ok";
         1: otag = "R3 result no-latch";
         2: otag = "R11 result rejected";
         default: otag = "R12 result timeout";
      endcase
      chk(got_code == 2'(ecode), otag, got_code, ecode);
      chk(got_l.size() == el.size(), "R2 R3 R12 frame count", got_l.size(), el.size());
      same = (got_b.size() == eb.size());
      if (same) foreach (eb[k]) if (got_b[k] != eb[k]) same = 0;
      chk(same, op ? "R5 program frame bytes" : "R4 erase frame bytes", got_b.size(), eb.size());
      if (got_l.size() > 0) chk(got_l[0] == 1 && got_b[0] == 8'h06, "R2 latch frame first", got_b[0], 6);
      chk(bits_bad == 0, "R6 partial byte frames", bits_bad, 0);
      chk(min_gap >= CS_GAP, "R7 cs high gap", min_gap, CS_GAP);
      chk(half_bad == 0, "R9 sck high phase", half_bad, 0);
      chk(done_cnt == 1, "R13 done pulses", done_cnt, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1 && spi_sck == 0, "R1 reset serial pins", {spi_cs_n, spi_sck}, 2);
      chk(req_ready == 1 && done == 0, "R1 reset handshake", {req_ready, done}, 2);
      @(posedge clk); #1 rst_n = 1;
      @(negedge clk);
      chk(spi_cs_n == 1 && req_ready == 1, "R1 after reset", {spi_cs_n, req_ready}, 3);
      run_op(0, 24'h12A5C3, 0, 0, 0, 3, 0);
      run_op(1, 24'h000100, 3, 0, 0, 2, 1);
      run_op(1, 24'hFF3E00, 255, 0, 0, 0, 0);
      run_op(0, 24'h7000A0, 0, 0, 1, 0, 0);
      run_op(1, 24'h000040, 1, 1, 0, 0, 0);
      run_op(0, 24'hABCDEF, 0, 0, 0, POLL_MAX, 0);
      run_op(0, 24'h010203, 0, 0, 0, POLL_MAX - 1, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(longint'(TCLK) * 200000);
      if (!finished) begin
         finished = 1;
         chk(0, "watchdog run hung", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule